// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an operand reference from a 16-bit processor into a memory address. A mode selector tells it how to form the 16-bit offset. The offset can be one pointer or index register plus a displacement. It can be a base register plus an index register, with or without a displacement. It can also be the instruction pointer, the stack pointer, or the string-destination index. The block then chooses which of the four segment registers qualifies the offset. It shifts that segment value left by four bits and adds the offset to form a 20-bit physical address.

The surrounding datapath supplies the register values and the decoded selections on a request strobe. One clock later the block presents the offset, a code naming the chosen segment, and the physical address, together with a valid flag. Between requests the outputs keep their last values.

Top module: `eag_top`

## Requirements
- R1: While reset is asserted and after its release, until the first request, `valid_o` is 0 and `ea_o`, `seg_o` and `pa_o` are all zero.
- R2: A request sampled at a rising edge makes `valid_o` 1 after that edge, with the results for the inputs that edge sampled. An edge without a request drives `valid_o` to 0 and leaves `ea_o`, `seg_o` and `pa_o` unchanged.
- R3: Mode 0 (single-register relative) adds a displacement to one register chosen by `reg_sel_i`: 0 picks BX, 1 picks BP, 2 picks SI and 3 picks DI.
- R4: With `disp_wide_i` = 0, only `disp_i[7:0]` is used, sign-extended from bit 7, and `disp_i[15:8]` has no effect. With `disp_wide_i` = 1, all 16 bits are used.
- R5: Mode 1 (based-indexed) adds a base register and an index register and ignores the displacement. For the base, `base_sel_i` = 0 picks BX and 1 picks BP. For the index, `idx_sel_i` = 0 picks SI and 1 picks DI.
- R6: Mode 2 (relative based-indexed) adds base, index and displacement, with the same selections as R5 and R4.
- R7: In modes 0, 1 and 2 without an override, the segment is SS when BP is the chosen register (mode 0) or the chosen base (modes 1 and 2). Otherwise the segment is DS.
- R8: Modes 6 and 7 (direct) use the displacement alone as the offset, with segment DS unless overridden.
- R9: Mode 3 yields CS with IP, mode 4 yields SS with SP, and mode 5 yields ES with DI. The override request has no effect in these three modes.
- R10: In modes 0, 1, 2, 6 and 7, `ovr_en_i` = 1 makes the segment the one coded on `ovr_seg_i`.
- R11: The offset sum wraps modulo 2^16. The physical address is the segment value times 16 plus the offset, modulo 2^20; for example, segment 345BH with offset 3000H gives 375B0H.
- R12: Segment codes on `seg_o` and `ovr_seg_i` are 0 for ES, 1 for CS, 2 for SS and 3 for DS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode |
| reg_sel_i | input | 2 | Register choice for mode 0 |
| base_sel_i | input | 1 | Base choice: 0 BX, 1 BP |
| idx_sel_i | input | 1 | Index choice: 0 SI, 1 DI |
| disp_i | input | 16 | Displacement |
| disp_wide_i | input | 1 | 1: 16-bit displacement, 0: sign-extended low byte |
| ovr_en_i | input | 1 | Segment override request |
| ovr_seg_i | input | 2 | Override segment code |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| ip_i | input | 16 | Instruction pointer |
| sp_i | input | 16 | Stack pointer |
| cs_i | input | 16 | Code segment value |
| ds_i | input | 16 | Data segment value |
| ss_i | input | 16 | Stack segment value |
| es_i | input | 16 | Extra segment value |
| valid_o | output | 1 | Result valid |
| ea_o | output | 16 | Effective address (offset) |
| seg_o | output | 2 | Chosen segment code |
| pa_o | output | 20 | Physical address |

## Verification
Assertions check the following on every cycle:
- the one-cycle valid timing and the holding of outputs when there is no request;
- the fixed segments for fetch and string-destination accesses, and the pairing of IP with CS;
- honouring of an override in data modes;
- the SS default for a BP base;
- the consistency of the physical address with the segment value chosen and the registered offset.

The offset arithmetic for each register selection cannot be checked this way. Neither can the sign extension of a short displacement, the modulo-2^16 and modulo-2^20 wrap points, or the worked 345BH:3000H example. These show only in the bench's directed scenarios, which compare the outputs against an independent model.

// File: rtl/eag_pkg.sv
package eag_pkg;
  parameter int OFS_W     = 16;
  parameter int SEG_SHIFT = 4;
  parameter int SHORT_W   = 8;
  localparam int PA_W     = OFS_W + SEG_SHIFT;

  typedef logic [OFS_W-1:0] ofs_t;
  typedef logic [PA_W-1:0]  pa_t;

  typedef enum logic [2:0] {
    AM_REL      = 3'd0,
    AM_BIDX     = 3'd1,
    AM_RBIDX    = 3'd2,
    AM_FETCH    = 3'd3,
    AM_STACK    = 3'd4,
    AM_STRDST   = 3'd5,
    AM_DIRECT   = 3'd6,
    AM_DIRECT_B = 3'd7
  } amode_t;

  // R12: segment code values
  typedef enum logic [1:0] {
    SG_ES = 2'd0,
    SG_CS = 2'd1,
    SG_SS = 2'd2,
    SG_DS = 2'd3
  } seg_t;

  // R4: short displacement is sign-extended from its top bit
  function automatic ofs_t disp_extend(ofs_t d, logic wide);
    if (wide) return d;
    return {{(OFS_W-SHORT_W){d[SHORT_W-1]}}, d[SHORT_W-1:0]};
  endfunction

  // R11: segment shifted left plus offset, truncated to PA_W bits
  function automatic pa_t phys_addr(ofs_t seg, ofs_t ofs);
    pa_t shifted;
    shifted = pa_t'(seg) << SEG_SHIFT;
    return shifted + pa_t'(ofs);
  endfunction

  // Modes where defaults may be overridden
  function automatic logic is_data_mode(logic [2:0] m);
    return !(m == AM_FETCH || m == AM_STACK || m == AM_STRDST);
  endfunction
endpackage

// File: rtl/eag_offset.sv
module eag_offset
  import eag_pkg::*;
(
  input  logic [2:0] mode,
  input  logic [1:0] reg_sel,
  input  logic       base_sel,
  input  logic       idx_sel,
  input  ofs_t       disp,
  input  logic       disp_wide,
  input  ofs_t       bx,
  input  ofs_t       bp,
  input  ofs_t       si,
  input  ofs_t       di,
  input  ofs_t       ip,
  input  ofs_t       sp,
  output ofs_t       ea,
  output logic       bp_based
);
  ofs_t disp_x, base_v, idx_v, rel_v;

  always_comb begin
    disp_x = disp_extend(disp, disp_wide);
    base_v = base_sel ? bp : bx;
    idx_v  = idx_sel ? di : si;
    case (reg_sel)
      2'd0:    rel_v = bx;
      2'd1:    rel_v = bp;
      2'd2:    rel_v = si;
      default: rel_v = di;
    endcase
  end

  always_comb begin
    bp_based = 1'b0;
    case (amode_t'(mode))
      AM_REL: begin
        ea       = rel_v + disp_x;
        bp_based = (reg_sel == 2'd1);
      end
      AM_BIDX: begin
        ea       = base_v + idx_v;
        bp_based = base_sel;
      end
      AM_RBIDX: begin
        ea       = base_v + idx_v + disp_x;
        bp_based = base_sel;
      end
      AM_FETCH:  ea = ip;
      AM_STACK:  ea = sp;
      AM_STRDST: ea = di;
      default:   ea = disp_x;
    endcase
  end
endmodule

// File: rtl/eag_segsel.sv
module eag_segsel
  import eag_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       bp_based,
  input  logic       ovr_en,
  input  logic [1:0] ovr_seg,
  input  ofs_t       cs,
  input  ofs_t       ds,
  input  ofs_t       ss,
  input  ofs_t       es,
  output seg_t       seg_code,
  output ofs_t       seg_val,
  output logic       ovr_taken
);
  seg_t dflt;

  always_comb begin
    case (amode_t'(mode))
      AM_FETCH:  dflt = SG_CS;
      AM_STACK:  dflt = SG_SS;
      AM_STRDST: dflt = SG_ES;
      default:   dflt = bp_based ? SG_SS : SG_DS;
    endcase
    ovr_taken = ovr_en && is_data_mode(mode);
    seg_code  = ovr_taken ? seg_t'(ovr_seg) : dflt;
    case (seg_code)
      SG_ES:   seg_val = es;
      SG_CS:   seg_val = cs;
      SG_SS:   seg_val = ss;
      default: seg_val = ds;
    endcase
  end
endmodule

// File: rtl/eag_phys.sv
module eag_phys
  import eag_pkg::*;
(
  input  ofs_t seg_val,
  input  ofs_t ofs,
  output pa_t  pa
);
  assign pa = phys_addr(seg_val, ofs);
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic [2:0]  mode_i,
  input  logic [1:0]  reg_sel_i,
  input  logic        base_sel_i,
  input  logic        idx_sel_i,
  input  logic [15:0] disp_i,
  input  logic        disp_wide_i,
  input  logic        ovr_en_i,
  input  logic [1:0]  ovr_seg_i,
  input  logic [15:0] bx_i,
  input  logic [15:0] bp_i,
  input  logic [15:0] si_i,
  input  logic [15:0] di_i,
  input  logic [15:0] ip_i,
  input  logic [15:0] sp_i,
  input  logic [15:0] cs_i,
  input  logic [15:0] ds_i,
  input  logic [15:0] ss_i,
  input  logic [15:0] es_i,
  output logic        valid_o,
  output logic [15:0] ea_o,
  output logic [1:0]  seg_o,
  output logic [19:0] pa_o
);
  ofs_t ea_w;
  logic bp_based_w;
  seg_t seg_code_w;
  ofs_t seg_val_w;
  logic ovr_taken_w;
  pa_t  pa_w;

  eag_offset u_ofs (
    .mode(mode_i), .reg_sel(reg_sel_i), .base_sel(base_sel_i),
    .idx_sel(idx_sel_i), .disp(disp_i), .disp_wide(disp_wide_i),
    .bx(bx_i), .bp(bp_i), .si(si_i), .di(di_i), .ip(ip_i), .sp(sp_i),
    .ea(ea_w), .bp_based(bp_based_w)
  );

  eag_segsel u_seg (
    .mode(mode_i), .bp_based(bp_based_w), .ovr_en(ovr_en_i),
    .ovr_seg(ovr_seg_i), .cs(cs_i), .ds(ds_i), .ss(ss_i), .es(es_i),
    .seg_code(seg_code_w), .seg_val(seg_val_w), .ovr_taken(ovr_taken_w)
  );

  eag_phys u_phys (
    .seg_val(seg_val_w), .ofs(ea_w), .pa(pa_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      ea_o    <= '0;
      seg_o   <= '0;
      pa_o    <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        ea_o  <= ea_w;
        seg_o <= seg_code_w;
        pa_o  <= pa_w;
      end
    end
  end

  // R2: valid one cycle after request
  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o);
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(ea_o) && $stable(seg_o) && $stable(pa_o)));
  // R9: fixed segments for fetch and string destination
  a_r9_fetch_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == AM_FETCH) |=> (seg_o == SG_CS && ea_o == $past(ip_i)));
  a_r9_strdst_es: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_i == AM_STRDST) |=> seg_o == SG_ES);
  // R10: override honoured in data modes
  a_r10_override: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && ovr_en_i && is_data_mode(mode_i)) |=> seg_o == $past(ovr_seg_i));
  // R7: BP base defaults to SS
  a_r7_bp_ss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !ovr_en_i && mode_i == AM_BIDX && base_sel_i) |=> seg_o == SG_SS);
  // R11: physical address consistent with chosen segment and offset
  a_r11_pa_form: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> pa_o == phys_addr($past(seg_val_w), ea_o));
endmodule

// File: tb/eag_top_test.sv
module eag_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  reg_sel_i = '0;
  logic        base_sel_i = 1'b0, idx_sel_i = 1'b0;
  logic [15:0] disp_i = '0;
  logic        disp_wide_i = 1'b0, ovr_en_i = 1'b0;
  logic [1:0]  ovr_seg_i = '0;
  logic [15:0] bx_i = '0, bp_i = '0, si_i = '0, di_i = '0, ip_i = '0, sp_i = '0;
  logic [15:0] cs_i = '0, ds_i = '0, ss_i = '0, es_i = '0;
  logic        valid_o;
  logic [15:0] ea_o;
  logic [1:0]  seg_o;
  logic [19:0] pa_o;

  int checks = 0;
  int errors = 0;
  int exp_ea, exp_seg, exp_pa;

  always #2 clk = ~clk;

  eag_top uut (.*);

  task automatic chk(string tag, int got, int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  // Independent model of the requirements
  task automatic model();
    int d, s, sv;
    bit bpb;
    d = disp_wide_i ? int'(disp_i) : (disp_i[7] ? int'(disp_i[7:0]) - 256 : int'(disp_i[7:0]));
    bpb = 0;
    case (mode_i)
      3'd0: begin
        case (reg_sel_i)
          2'd0: s = bx_i; 2'd1: s = bp_i; 2'd2: s = si_i; default: s = di_i;
        endcase
        s = s + d; bpb = (reg_sel_i == 2'd1);
      end
      3'd1: begin s = (base_sel_i ? bp_i : bx_i) + (idx_sel_i ? di_i : si_i); bpb = base_sel_i; end
      3'd2: begin s = (base_sel_i ? bp_i : bx_i) + (idx_sel_i ? di_i : si_i) + d; bpb = base_sel_i; end
      3'd3: s = ip_i;
      3'd4: s = sp_i;
      3'd5: s = di_i;
      default: s = d;
    endcase
    exp_ea = ((s % 65536) + 65536) % 65536;
    if (mode_i == 3'd3) exp_seg = 1;
    else if (mode_i == 3'd4) exp_seg = 2;
    else if (mode_i == 3'd5) exp_seg = 0;
    else if (ovr_en_i) exp_seg = ovr_seg_i;
    else exp_seg = bpb ? 2 : 3;
    case (exp_seg)
      0: sv = es_i; 1: sv = cs_i; 2: sv = ss_i; default: sv = ds_i;
    endcase
    exp_pa = (sv * 16 + exp_ea) % 1048576;
  endtask

  task automatic issue(string tag);
    model();
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk({tag, " R2 valid"}, valid_o, 1);
    chk({tag, " ea"}, ea_o, exp_ea);
    chk({tag, " seg"}, seg_o, exp_seg);
    chk({tag, " pa"}, pa_o, exp_pa);
  endtask

  task automatic set_regs();
    bx_i = 16'h1200; bp_i = 16'h2400; si_i = 16'h0030; di_i = 16'h0507;
    ip_i = 16'h0100; sp_i = 16'hFFFE;
    cs_i = 16'h1000; ds_i = 16'h2000; ss_i = 16'h3000; es_i = 16'h4000;
    ovr_en_i = 0; disp_wide_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 valid", valid_o, 0);
    chk("R1 ea", ea_o, 0);
    chk("R1 seg", seg_o, 0);
    chk("R1 pa", pa_o, 0);
  endtask

  task automatic t_rel();
    set_regs(); mode_i = 3'd0;
    for (int r = 0; r < 4; r++) begin
      reg_sel_i = 2'(r); disp_i = 16'h7F80; disp_wide_i = 0;
      issue($sformatf("R3 R4 R7 rel sel%0d short", r));
      disp_i = 16'h1234; disp_wide_i = 1;
      issue($sformatf("R3 rel sel%0d wide", r));
    end
    // R4: high byte ignored for short displacement
    disp_wide_i = 0; reg_sel_i = 2'd0; disp_i = 16'hAA05;
    issue("R4 high byte ignored");
    chk("R4 ea literal", ea_o, 16'h1205);
  endtask

  task automatic t_bidx();
    set_regs(); disp_i = 16'h5555; disp_wide_i = 1;
    for (int m = 1; m <= 2; m++)
      for (int b = 0; b < 2; b++)
        for (int x = 0; x < 2; x++) begin
          mode_i = 3'(m); base_sel_i = b[0]; idx_sel_i = x[0];
          issue($sformatf("R5 R6 R7 mode%0d b%0d x%0d", m, b, x));
        end
    // R11: offset wrap
    mode_i = 3'd2; bx_i = 16'hFFFF; si_i = 16'h0002; base_sel_i = 0; idx_sel_i = 0;
    disp_i = 16'h0001; disp_wide_i = 1;
    issue("R11 offset wrap");
    chk("R11 wrap literal", ea_o, 16'h0002);
  endtask

  task automatic t_fixed();
    set_regs(); ovr_en_i = 1; ovr_seg_i = 2'd3;
    mode_i = 3'd3; issue("R9 fetch ignores override");
    chk("R9 fetch CS", seg_o, 1);
    mode_i = 3'd4; issue("R9 stack ignores override");
    chk("R9 stack SS", seg_o, 2);
    mode_i = 3'd5; ovr_seg_i = 2'd1; issue("R9 strdst ignores override");
    chk("R9 strdst ES", seg_o, 0);
  endtask

  task automatic t_override();
    set_regs(); ovr_en_i = 1;
    for (int s = 0; s < 4; s++) begin
      ovr_seg_i = 2'(s);
      mode_i = 3'd1; base_sel_i = 1; issue($sformatf("R10 R12 bidx ovr%0d", s));
      mode_i = 3'd6; disp_i = 16'h0044; issue($sformatf("R10 R8 direct ovr%0d", s));
    end
  endtask

  task automatic t_phys();
    set_regs(); mode_i = 3'd6; ds_i = 16'h345B; disp_i = 16'h3000; disp_wide_i = 1;
    issue("R8 R11 example");
    chk("R11 example 375B0", pa_o, 20'h375B0);
    mode_i = 3'd7; ds_i = 16'hFFFF; disp_i = 16'h0020;
    issue("R8 R11 pa wrap");
    chk("R11 pa wrap literal", pa_o, 20'h00010);
    mode_i = 3'd7; disp_i = 16'h0090; disp_wide_i = 0;
    issue("R4 R8 direct short negative");
  endtask

  task automatic t_hold();
    int e, s, p;
    set_regs(); mode_i = 3'd0; reg_sel_i = 2'd2; disp_i = 16'h0010;
    issue("R2 pre-hold");
    e = ea_o; s = seg_o; p = pa_o;
    bx_i = 16'hDEAD; si_i = 16'hBEEF; ds_i = 16'h7777; mode_i = 3'd3;
    @(negedge clk);
    chk("R2 idle valid", valid_o, 0);
    chk("R2 hold ea", ea_o, e);
    chk("R2 hold seg", seg_o, s);
    chk("R2 hold pa", pa_o, p);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rel();
    t_bidx();
    t_fixed();
    t_override();
    t_phys();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule